// File: doc/BRIEF.md
# SPI Configuration Register Responder

This block is the serial slave front end that serves one configuration register of a memory device. While chip select is low it shifts in an 8-bit command on the data input, sampling on the rising serial clock edge. A read command returns the configuration byte on the serial output, most significant bit first, changing on the falling clock edge, and repeats that byte for as long as select stays low. A write command takes one following data byte and uses only its top bit, the quad-enable flag. The flag is driven out so that command gating further along can use it.

The serial pins are sampled on the block's own system clock, through a synchronizer whose depth is a parameter. The stored flag is never cleared by the block reset. It is loaded from a separate initial-value input whenever a load strobe is high, which models a value that persists across power cycles. A busy input from the status logic refuses reads while the device is working.

Top module: `cfgspi_resp`

## Requirements
- R1: A command is 8 bits, most significant bit first, sampled on rising serial clock edges while chip select is low; the read command code is 0x3F.
- R2: After a read command, the serial output is enabled from the first falling edge after the 8th command bit and carries the configuration byte most significant bit first, one bit per falling edge.
- R3: The configuration byte repeats without a gap for as long as chip select stays low and the clock keeps running.
- R4: Raising chip select at any point, including in the middle of a byte, disables the serial output enable at once, with no system-clock delay.
- R5: When the busy input is high at the 8th command bit of a read, the serial output stays disabled until chip select rises.
- R6: Bit 7 of the returned byte equals the quad-enable output; bits 6 to 0 always read 0.
- R7: The write command code (default 0x3E) followed by exactly 8 data bits and then a rise of chip select sets the quad-enable flag to data bit 7; with fewer or more data bits the flag is left unchanged, and data bits 6 to 0 have no effect.
- R8: The block reset leaves the quad-enable flag unchanged; a high load strobe copies the initial-value input into the flag.
- R9: After any other command code the serial output stays disabled and later bits in the same selection, including a read code, are ignored.
- R10: Each fall of chip select starts a fresh command decode, so an aborted command has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset of the serial state |
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| busy_i | input | 1 | Device busy flag from the status logic |
| cfg_load_i | input | 1 | Strobe that loads the quad-enable flag from the initial value |
| cfg_qe_init_i | input | 1 | Initial value of the quad-enable flag |
| so_o | output | 1 | Serial data out, 0 while not enabled |
| so_oe_o | output | 1 | Output enable for the serial data out pad |
| qe_o | output | 1 | Quad-enable flag for downstream command gating |

## Verification
The bench goes after the write length rule by sending 7, 8 and 9 data bits with bit 7 set. A design that counts loosely would change the flag on the short or long frame. It reads two whole bytes per read to catch a shifter that stops or drops a bit after the first byte, and it reads with the flag both set and clear to catch reserved bits that leak data. It raises select in mid-byte and looks at the enable in the same instant, which exposes a release that waits for the synchronizer. It pulses reset after the flag was set, which shows whether reset wrongly clears the flag. It also sends a read code after an unknown command, which catches a decoder that starts decoding again inside the same selection.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
   typedef enum logic [1:0] {
      ST_OPC   = 2'd0,
      ST_READ  = 2'd1,
      ST_WDATA = 2'd2,
      ST_SKIP  = 2'd3
   } dec_state_t;
endpackage

// File: rtl/cfgspi_pin_sync.sv
module cfgspi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic si_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_hi,
   output logic cs_rise,
   output logic si_s
);
   logic sck_s, cs_s;
   logic sck_d, cs_d;

   generate
      if (STAGES == 0) begin : g_direct
         assign sck_s = sck_i;
         assign cs_s  = cs_n_i;
         assign si_s  = si_i;
      end else begin : g_chain
         logic [2:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
            end else begin
               for (int i = STAGES - 1; i > 0; i--) pipe[i] <= pipe[i-1];
               pipe[0] <= {sck_i, cs_n_i, si_i};
            end
         end
         assign sck_s = pipe[STAGES-1][2];
         assign cs_s  = pipe[STAGES-1][1];
         assign si_s  = pipe[STAGES-1][0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign cs_hi    = cs_s;
   assign cs_rise  = cs_s & ~cs_d;
endmodule

// File: rtl/cfgspi_cmd_dec.sv
module cfgspi_cmd_dec
   import cfgspi_pkg::*;
#(
   parameter int          CMD_W  = 8,
   parameter int          DATA_W = 8,
   parameter logic [7:0]  RD_OP  = 8'h3F,
   parameter logic [7:0]  WR_OP  = 8'h3E
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_hi,
   input  logic cs_rise,
   input  logic sck_rise,
   input  logic si,
   input  logic busy_i,
   output logic rd_act,
   output logic commit,
   output logic wr_bit
);
   localparam int CNT_W = $clog2(((CMD_W > DATA_W) ? CMD_W : DATA_W) + 2);
   localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] DATA_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] DATA_OVER = CNT_W'(DATA_W + 1);

   dec_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CMD_W-1:0]  opc_q;
   logic [DATA_W-1:0] dat_q;
   logic [CMD_W-1:0]  opc_full;

   assign opc_full = {opc_q[CMD_W-2:0], si};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OPC;
         cnt_q   <= '0;
         opc_q   <= '0;
         dat_q   <= '0;
      end else if (cs_hi) begin
         state_q <= ST_OPC;
         cnt_q   <= '0;
      end else if (sck_rise) begin
         case (state_q)
            ST_OPC: begin
               opc_q <= opc_full;
               if (cnt_q == OPC_LAST) begin
                  cnt_q <= '0;
                  if (opc_full == CMD_W'(RD_OP))
                     state_q <= busy_i ? ST_SKIP : ST_READ;
                  else if (opc_full == CMD_W'(WR_OP))
                     state_q <= ST_WDATA;
                  else
                     state_q <= ST_SKIP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_WDATA: begin
               dat_q <= {dat_q[DATA_W-2:0], si};
               if (cnt_q != DATA_OVER) cnt_q <= cnt_q + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign rd_act = (state_q == ST_READ) & ~cs_hi;
   assign commit = cs_rise & (state_q == ST_WDATA) & (cnt_q == DATA_FULL);
   assign wr_bit = dat_q[DATA_W-1];

   // R5: a busy read at the last command bit never enters the read state
   p_busy_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && !cs_hi && state_q == ST_OPC && cnt_q == OPC_LAST &&
       opc_full == CMD_W'(RD_OP) && busy_i) |=> state_q != ST_READ);

   // R9: a refused or unknown command stays skipped while selected
   p_skip_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP && !cs_hi) |=> state_q == ST_SKIP || $past(cs_hi) || cs_hi);

   // R10: selection released always returns decode to the command phase
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (state_q == ST_OPC && cnt_q == '0));
endmodule

// File: rtl/cfgspi_so_shift.sv
module cfgspi_so_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic              sck_fall,
   input  logic [DATA_W-1:0] cfg_byte,
   output logic              so_q,
   output logic              oe_q
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so_q  <= 1'b0;
         oe_q  <= 1'b0;
         idx_q <= IDX_TOP;
      end else if (!rd_act) begin
         so_q  <= 1'b0;
         oe_q  <= 1'b0;
         idx_q <= IDX_TOP;
      end else if (sck_fall) begin
         so_q  <= cfg_byte[idx_q];
         oe_q  <= 1'b1;
         idx_q <= (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
      end
   end

   // R2: output is enabled only on a falling edge of an active read
   p_oe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(rd_act && sck_fall));

   // R3: the bit index wraps so the byte repeats while the read lasts
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && sck_fall && idx_q == '0) |=> (idx_q == IDX_TOP || !$past(rd_act)));
endmodule

// File: rtl/cfgspi_resp.sv
module cfgspi_resp #(
   parameter int         SYNC_STAGES = 2,
   parameter int         CMD_W       = 8,
   parameter int         DATA_W      = 8,
   parameter logic [7:0] RD_OP       = 8'h3F,
   parameter logic [7:0] WR_OP       = 8'h3E
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic si_i,
   input  logic busy_i,
   input  logic cfg_load_i,
   input  logic cfg_qe_init_i,
   output logic so_o,
   output logic so_oe_o,
   output logic qe_o
);
   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (CMD_W < 2 || CMD_W > 8 || DATA_W < 2) begin : g_bad_width
         $error("CMD_W must be 2 to 8 and DATA_W at least 2");
      end
      if (RD_OP == WR_OP) begin : g_bad_ops
         $error("read and write command codes must differ");
      end
   endgenerate

   logic sck_rise, sck_fall, cs_hi, cs_rise, si_s;
   logic rd_act, commit, wr_bit;
   logic so_q, oe_q;
   logic qe_q;
   logic [DATA_W-1:0] cfg_byte;

   cfgspi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_i    (sck_i),
      .cs_n_i   (cs_n_i),
      .si_i     (si_i),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_hi    (cs_hi),
      .cs_rise  (cs_rise),
      .si_s     (si_s)
   );

   cfgspi_cmd_dec #(
      .CMD_W (CMD_W), .DATA_W (DATA_W), .RD_OP (RD_OP), .WR_OP (WR_OP)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_hi    (cs_hi),
      .cs_rise  (cs_rise),
      .sck_rise (sck_rise),
      .si       (si_s),
      .busy_i   (busy_i),
      .rd_act   (rd_act),
      .commit   (commit),
      .wr_bit   (wr_bit)
   );

   // Persistent flag: no reset term by intent
   always_ff @(posedge clk) begin
      if (cfg_load_i)  qe_q <= cfg_qe_init_i;
      else if (commit) qe_q <= wr_bit;
   end

   assign cfg_byte = {qe_q, {(DATA_W-1){1'b0}}};

   cfgspi_so_shift #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (rd_act),
      .sck_fall (sck_fall),
      .cfg_byte (cfg_byte),
      .so_q     (so_q),
      .oe_q     (oe_q)
   );

   assign so_oe_o = oe_q & ~cs_n_i;
   assign so_o    = so_oe_o & so_q;
   assign qe_o    = qe_q;

   // R8 / R7: the flag moves only by load or a committed write
   p_qe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(qe_q) |-> $past(cfg_load_i || commit));

   // R4: synchronized deselect clears the registered enable next cycle
   p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !oe_q);

   // R2: enabled output always belongs to an active read
   p_oe_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_act |=> !oe_q);
endmodule

// File: tb/cfgspi_resp_tb.sv
`timescale 1ns/1ps
module cfgspi_resp_tb_top;
   localparam int H = 6;

   typedef struct packed {
      logic [7:0] op;
      logic [7:0] dat;
      logic [4:0] nb;
      logic       bsy;
      logic       exp_oe;
      logic [7:0] exp_rd;
      logic       exp_qe;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{8'h3F, 8'h00, 5'd16, 1'b0, 1'b1, 8'h80, 1'b1, 4'd3},  // R1 R2 R3: read, flag set
      '{8'h3E, 8'h00, 5'd8,  1'b0, 1'b0, 8'h00, 1'b0, 4'd7},  // R7: write clears flag
      '{8'h3F, 8'h00, 5'd16, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6: read, flag clear
      '{8'h3E, 8'hFF, 5'd7,  1'b0, 1'b0, 8'h00, 1'b0, 4'd7},  // R7: short write ignored
      '{8'h3E, 8'hFF, 5'd9,  1'b0, 1'b0, 8'h00, 1'b0, 4'd7},  // R7: long write ignored
      '{8'h3E, 8'h80, 5'd8,  1'b0, 1'b0, 8'h00, 1'b1, 4'd7},  // R7: write sets flag
      '{8'h3F, 8'h00, 5'd16, 1'b1, 1'b0, 8'h00, 1'b1, 4'd5},  // R5: busy refuses read
      '{8'hA5, 8'h3F, 5'd16, 1'b0, 1'b0, 8'h00, 1'b1, 4'd9},  // R9: unknown then read code
      '{8'h3E, 8'h7F, 5'd8,  1'b0, 1'b0, 8'h00, 1'b0, 4'd7},  // R7: low bits no effect
      '{8'h3F, 8'h00, 5'd16, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6: reserved bits zero
      '{8'h3E, 8'hC0, 5'd8,  1'b0, 1'b0, 8'h00, 1'b1, 4'd7},  // R7
      '{8'h3F, 8'h00, 5'd16, 1'b0, 1'b1, 8'h80, 1'b1, 4'd2}   // R2
   };

   logic clk = 1'b0;
   logic rst_n, sck, cs_n, si, busy, load, qe_init;
   logic so, so_oe, qe;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfgspi_resp dut_i (
      .clk (clk), .rst_n (rst_n), .sck_i (sck), .cs_n_i (cs_n), .si_i (si),
      .busy_i (busy), .cfg_load_i (load), .cfg_qe_init_i (qe_init),
      .so_o (so), .so_oe_o (so_oe), .qe_o (qe)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         si = b[7 - (i % 8)];
         wait_clk(H); sck = 1'b1;
         wait_clk(H); sck = 1'b0;
      end
   endtask

   task automatic run_txn(input vec_t v, output logic [15:0] rd,
                          output logic any_oe, output logic all_oe);
      rd = '0; any_oe = 1'b0; all_oe = 1'b1;
      busy = v.bsy;
      cs_n = 1'b0;
      wait_clk(8);
      send_bits(v.op, 8);
      for (int i = 0; i < int'(v.nb); i++) begin
         si = v.dat[7 - (i % 8)];
         wait_clk(H);
         rd = {rd[14:0], so};
         any_oe = any_oe | so_oe;
         all_oe = all_oe & so_oe;
         sck = 1'b1;
         wait_clk(H); sck = 1'b0;
      end
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(10);
      busy = 1'b0;
   endtask

   initial begin
      logic [15:0] rd;
      logic any_oe, all_oe;
      rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
      busy = 1'b0; load = 1'b0; qe_init = 1'b0;
      wait_clk(3);
      qe_init = 1'b1; load = 1'b1;
      wait_clk(1);
      load = 1'b0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      check("reset so_oe R4", {7'd0, so_oe}, 8'h00);
      check("init load R8", {7'd0, qe}, 8'h01);

      for (int k = 0; k < NV; k++) begin
         run_txn(VECS[k], rd, any_oe, all_oe);
         if (VECS[k].exp_oe) begin
            check($sformatf("vec%0d R%0d oe", k, VECS[k].req), {7'd0, all_oe}, 8'h01);
            check($sformatf("vec%0d R%0d byte0", k, VECS[k].req), rd[15:8], VECS[k].exp_rd);
            check($sformatf("vec%0d R3 byte1", k), rd[7:0], VECS[k].exp_rd);
         end else begin
            check($sformatf("vec%0d R%0d no oe", k, VECS[k].req), {7'd0, any_oe}, 8'h00);
         end
         check($sformatf("vec%0d R%0d qe", k, VECS[k].req), {7'd0, qe}, {7'd0, VECS[k].exp_qe});
      end

      // R4: mid-byte deselect drops enable at once
      cs_n = 1'b0;
      wait_clk(8);
      send_bits(8'h3F, 8);
      send_bits(8'h00, 3);
      wait_clk(H);
      check("R4 enabled before deselect", {7'd0, so_oe}, 8'h01);
      cs_n = 1'b1;
      #1;
      check("R4 immediate release", {7'd0, so_oe}, 8'h00);
      wait_clk(10);

      // R10: aborted partial command, then a clean read
      cs_n = 1'b0;
      wait_clk(8);
      send_bits(8'h3F, 4);
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(10);
      run_txn('{8'h3F, 8'h00, 5'd16, 1'b0, 1'b1, 8'h80, 1'b1, 4'd10}, rd, any_oe, all_oe);
      check("R10 read after abort", rd[15:8], 8'h80);
      check("R10 oe after abort", {7'd0, all_oe}, 8'h01);

      // R8: reset keeps the flag, load replaces it
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      check("R8 flag kept over reset", {7'd0, qe}, 8'h01);
      qe_init = 1'b0; load = 1'b1;
      wait_clk(1);
      load = 1'b0;
      wait_clk(2);
      check("R8 load clears flag", {7'd0, qe}, 8'h00);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule